// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects ten interrupt request lines and asks the core to take the most urgent eligible one. The lines have a fixed rank, and index 0 is the most urgent. Each request is caught in a pending latch. Software can block sources one at a time through a mask register, and it can gate the whole controller with a global enable. The block presents a vector address to the core. That address is the entry for the winning source in a table of 4-byte slots that starts at address 0 of local memory.

When the core acknowledges, the winning source moves from pending to in-service. While handlers run, the in-service register works as a stack of active priority levels. A new request is presented only if it outranks every level that is already active. So a more urgent source can interrupt a running handler, while a source of the same rank or a lower rank waits. A return-from-interrupt pulse retires the most urgent active level. Software reads and writes the mask, pending and in-service registers through a small select/write port. It can save and restore them, and it can raise a source in software.

Top module: `pic_nest_ctrl`

## Requirements
- R1: After reset, irq_o is low and the mask, pending, in-service and global-enable state all read as zero.
- R2: A source line that is high at a clock edge sets its pending bit. The bit stays set until an acknowledge of that source or a software write to pending clears it. The pending register reads back with select code 1.
- R3: The fixed rank, from most to least urgent, is: index 0 sync/reset, 1 software exception, 2 memory fault, 3 timer 0, 4 timer 1, 5 DMA 0 done, 6 DMA 1 done, 7 wired-AND, 8 reserved, 9 user. Among the eligible sources, the one with the lowest index is presented, with vec_o equal to the index times 4.
- R4: A mask bit of 1 (mask register, select code 0) stops sources 1 to 9 from being presented, while their pending bit is kept. Source 0 ignores its mask bit.
- R5: irq_o is high only while global enable is set. A set pulse enables, and a clear pulse disables. When both pulses arrive together, the clear wins. Enable reads back in bit 0 under select code 3.
- R6: ack_i while irq_o is high clears the presented source's pending bit and sets its in-service bit (select code 2). ack_i while irq_o is low changes nothing.
- R7: A pending, unmasked source is presented only if its index is strictly lower than the index of every set in-service bit. A source of equal or lower rank waits.
- R8: rti_i clears only the lowest-index set in-service bit. If rti_i and ack_i arrive in the same cycle, the clear applies to the old stack and the new bit is then added.
- R9: Line 8 is reserved. It never sets pending, not even through a software write, so it is never presented.
- R10: A register write replaces the selected register and takes priority over an acknowledge or return in the same cycle. Source lines that are high in the same cycle are ORed into pending after a pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 10 | Interrupt request lines, index 0 most urgent |
| gie_set_i | input | 1 | Global enable set pulse |
| gie_clr_i | input | 1 | Global enable clear pulse |
| ack_i | input | 1 | Core acknowledge of the presented request |
| rti_i | input | 1 | Return-from-interrupt pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 pending, 2 in-service, 3 control |
| reg_wdata_i | input | 10 | Register write data |
| reg_rdata_o | output | 10 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Vector address of the presented source |

## Verification
The bench drives a nesting scenario in which a masked memory fault stays pending under a timer handler and then preempts that handler once unmasked. A design that let equal-rank sources nest would present timer 1 again while timer 1 is still in service. A design whose return retired the wrong level would leave the outer handler's bit set or clear it too early, and the in-service readback would show this. The bench also checks the following corners, each of which shows up as a wrong readback or a spurious irq_o:
- an acknowledge with no request presented, which a faulty design would turn into a phantom in-service bit;
- the sync source under a full mask;
- the reserved line, driven both by wire and by software;
- a combined set/clear of the enable;
- an acknowledge and a return in the same cycle.

// File: rtl/pic_nest_pkg.sv
package pic_nest_pkg;
  localparam int unsigned SRC_N       = 10;
  localparam int unsigned RSV_IDX     = 8;
  localparam int unsigned NOMASK_IDX  = 0;
  localparam int unsigned VEC_STRIDE  = 4;
  localparam int unsigned VEC_W       = 8;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ISVC = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pic_nest_pick.sv
// Finds the lowest set index (most urgent) of a request vector.
module pic_nest_pick #(
  parameter int unsigned N     = 10,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_nest_regs.sv
module pic_nest_regs
  import pic_nest_pkg::*;
#(
  parameter int unsigned N      = SRC_N,
  parameter int unsigned RSV    = RSV_IDX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_src_i,
  input  logic         gie_set_i,
  input  logic         gie_clr_i,
  input  logic         reg_we_i,
  input  reg_sel_e     reg_sel_i,
  input  logic [N-1:0] reg_wdata_i,
  input  logic [N-1:0] take_oh_i,
  input  logic [N-1:0] rti_oh_i,
  output logic [N-1:0] mask_q_o,
  output logic [N-1:0] pend_q_o,
  output logic [N-1:0] isvc_q_o,
  output logic         gie_q_o
);
  localparam logic [N-1:0] RSV_BIT = {{(N-1){1'b0}}, 1'b1} << RSV;

  logic [N-1:0] mask_q, pend_q, isvc_q;
  logic [N-1:0] mask_d, pend_d, isvc_d;
  logic         gie_q, gie_d;
  logic         wr_mask, wr_pend, wr_isvc;

  assign wr_mask = reg_we_i && (reg_sel_i == SEL_MASK);
  assign wr_pend = reg_we_i && (reg_sel_i == SEL_PEND);
  assign wr_isvc = reg_we_i && (reg_sel_i == SEL_ISVC);

  always_comb begin
    mask_d = wr_mask ? reg_wdata_i : mask_q;

    pend_d = pend_q & ~take_oh_i;
    if (wr_pend) pend_d = reg_wdata_i;
    // live lines land after a software write; reserved slot never latches
    pend_d = (pend_d | irq_src_i) & ~RSV_BIT;

    isvc_d = (isvc_q & ~rti_oh_i) | take_oh_i;
    if (wr_isvc) isvc_d = reg_wdata_i;

    gie_d = gie_q;
    if (gie_set_i) gie_d = 1'b1;
    if (gie_clr_i) gie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      isvc_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      isvc_q <= isvc_d;
      gie_q  <= gie_d;
    end
  end

  assign mask_q_o = mask_q;
  assign pend_q_o = pend_q;
  assign isvc_q_o = isvc_q;
  assign gie_q_o  = gie_q;
endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl
  import pic_nest_pkg::*;
#(
  parameter int unsigned N        = SRC_N,
  parameter int unsigned RSV      = RSV_IDX,
  parameter int unsigned NOMASK   = NOMASK_IDX,
  parameter int unsigned STRIDE   = VEC_STRIDE,
  parameter int unsigned VW       = VEC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_src_i,
  input  logic          gie_set_i,
  input  logic          gie_clr_i,
  input  logic          ack_i,
  input  logic          rti_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [N-1:0]  reg_wdata_i,
  output logic [N-1:0]  reg_rdata_o,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  localparam int unsigned IDX_W      = $clog2(N);
  localparam logic [N-1:0] NOMASK_BIT = {{(N-1){1'b0}}, 1'b1} << NOMASK;

  reg_sel_e         sel;
  logic [N-1:0]     mask_q, pend_q, isvc_q;
  logic             gie_q;
  logic [N-1:0]     elig;
  logic             cand_found, isvc_found;
  logic [IDX_W-1:0] cand_idx, isvc_idx;
  logic             present, take;
  logic [N-1:0]     take_oh, rti_oh;

  assign sel = reg_sel_e'(reg_sel_i);

  pic_nest_regs #(.N(N), .RSV(RSV)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_src_i   (irq_src_i),
    .gie_set_i   (gie_set_i),
    .gie_clr_i   (gie_clr_i),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (sel),
    .reg_wdata_i (reg_wdata_i),
    .take_oh_i   (take_oh),
    .rti_oh_i    (rti_oh),
    .mask_q_o    (mask_q),
    .pend_q_o    (pend_q),
    .isvc_q_o    (isvc_q),
    .gie_q_o     (gie_q)
  );

  assign elig = pend_q & ~(mask_q & ~NOMASK_BIT);

  pic_nest_pick #(.N(N)) u_pick_req (
    .vec_i   (elig),
    .found_o (cand_found),
    .idx_o   (cand_idx)
  );

  pic_nest_pick #(.N(N)) u_pick_svc (
    .vec_i   (isvc_q),
    .found_o (isvc_found),
    .idx_o   (isvc_idx)
  );

  // strict preemption: must outrank every active level
  assign present = gie_q && cand_found && (!isvc_found || (cand_idx < isvc_idx));
  assign take    = present && ack_i;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign take_oh[g] = take && (cand_idx == IDX_W'(g));
    assign rti_oh[g]  = rti_i && isvc_found && (isvc_idx == IDX_W'(g));
  end

  assign irq_o = present;
  assign vec_o = present ? (VW'(cand_idx) * VW'(STRIDE)) : '0;

  always_comb begin
    unique case (sel)
      SEL_MASK: reg_rdata_o = mask_q;
      SEL_PEND: reg_rdata_o = pend_q;
      SEL_ISVC: reg_rdata_o = isvc_q;
      default:  reg_rdata_o = {{(N-1){1'b0}}, gie_q};
    endcase
  end
endmodule

// File: rtl/pic_nest_ctrl_chk.sv
module pic_nest_ctrl_chk #(
  parameter int unsigned N      = 10,
  parameter int unsigned RSV    = 8,
  parameter int unsigned NOMASK = 0,
  parameter int unsigned STRIDE = 4,
  parameter int unsigned VW     = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic          ack_i,
  input logic          rti_i,
  input logic          reg_we_i,
  input logic          gie_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  isvc_q
);
  logic [VW-1:0] vidx;
  logic [N-1:0]  src_oh, upto;

  assign vidx = vec_o / VW'(STRIDE);

  always_comb begin
    src_oh = '0;
    upto   = '0;
    for (int i = 0; i < N; i++) begin
      src_oh[i] = (vidx == VW'(i));
      upto[i]   = (VW'(i) <= vidx);
    end
  end

  // R5
  irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_q);

  // R3
  irq_src_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((src_oh & pend_q) != '0));

  // R4
  irq_src_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !src_oh[NOMASK]) |-> ((src_oh & mask_q) == '0));

  // R7
  irq_outranks_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((isvc_q & upto) == '0));

  // R9
  irq_not_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !src_oh[RSV]);

  // R6
  ack_pushes_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !rti_i && !reg_we_i)
      |=> ($countones(isvc_q) == $past($countones(isvc_q)) + 1));

  // R8
  rti_pops_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_i && !ack_i && !reg_we_i && (isvc_q != '0))
      |=> ($countones(isvc_q) + 1 == $past($countones(isvc_q))));
endmodule

bind pic_nest_ctrl pic_nest_ctrl_chk #(
  .N(N), .RSV(RSV), .NOMASK(NOMASK), .STRIDE(STRIDE), .VW(VW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .vec_o    (vec_o),
  .ack_i    (ack_i),
  .rti_i    (rti_i),
  .reg_we_i (reg_we_i),
  .gie_q    (gie_q),
  .mask_q   (mask_q),
  .pend_q   (pend_q),
  .isvc_q   (isvc_q)
);

// File: tb/pic_nest_ctrl_tb_top.sv
module pic_nest_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_MASK = 2'd0, S_PEND = 2'd1, S_ISVC = 2'd2, S_CTRL = 2'd3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] irq_src = '0;
  logic       gie_set = 0, gie_clr = 0, ack = 0, rti = 0, reg_we = 0;
  logic [1:0] reg_sel = '0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  logic       irq_o;
  logic [7:0] vec_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pic_nest_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .irq_src_i   (irq_src),
    .gie_set_i   (gie_set),
    .gie_clr_i   (gie_clr),
    .ack_i       (ack),
    .rti_i       (rti),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq_o),
    .vec_o       (vec_o)
  );

  typedef struct {
    bit         exp_irq;
    logic [7:0] exp_vec;
    logic [9:0] exp_rd;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if (irq_o !== it.exp_irq || (it.exp_irq && vec_o !== it.exp_vec)) begin
        n_bad++;
        $display("FAIL %s: irq/vec got %b/%0d expected %b/%0d",
                 it.tag, irq_o, vec_o, it.exp_irq, it.exp_vec);
      end else if (reg_rdata !== it.exp_rd) begin
        n_bad++;
        $display("FAIL %s: rdata got 0x%03h expected 0x%03h",
                 it.tag, reg_rdata, it.exp_rd);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    irq_src = '0; gie_set = 0; gie_clr = 0; ack = 0; rti = 0; reg_we = 0;
  endtask

  task automatic expect_st(logic [1:0] sel, logic [9:0] rd, bit irq, int idx, string tag);
    item_t it;
    reg_sel    = sel;
    it.exp_irq = irq;
    it.exp_vec = 8'(idx * 4);
    it.exp_rd  = rd;
    it.tag     = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [9:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    expect_st(S_MASK, 10'h000, 0, 0, "R1 mask");
    expect_st(S_PEND, 10'h000, 0, 0, "R1 pend");
    expect_st(S_ISVC, 10'h000, 0, 0, "R1 isvc");
    expect_st(S_CTRL, 10'h000, 0, 0, "R1 ctrl");

    // R2 latch with enable off; R5 nothing presented
    irq_src[4] = 1; tick();
    expect_st(S_PEND, 10'h010, 0, 0, "R2 pend latch, R5 gie off");
    tick();
    expect_st(S_PEND, 10'h010, 0, 0, "R2 pend held");

    gie_set = 1; tick();
    expect_st(S_CTRL, 10'h001, 1, 4, "R5 enable, R3 vec timer1");

    irq_src[7] = 1; irq_src[2] = 1; tick();
    expect_st(S_PEND, 10'h094, 1, 2, "R3 lowest index wins");

    wr(S_MASK, 10'h004); tick();
    expect_st(S_MASK, 10'h004, 1, 4, "R4 masked fault skipped");

    ack = 1; tick();
    expect_st(S_PEND, 10'h084, 0, 0, "R6 ack clears pend, R7 lower waits");
    expect_st(S_ISVC, 10'h010, 0, 0, "R6 ack sets isvc");

    wr(S_MASK, 10'h000); tick();
    expect_st(S_ISVC, 10'h010, 1, 2, "R7 higher preempts");

    ack = 1; tick();
    expect_st(S_ISVC, 10'h014, 0, 0, "R6 nested isvc");

    irq_src[4] = 1; tick();
    expect_st(S_PEND, 10'h090, 0, 0, "R7 waits under fault");

    rti = 1; tick();
    expect_st(S_ISVC, 10'h010, 0, 0, "R8 pops top, R7 equal waits");

    rti = 1; tick();
    expect_st(S_ISVC, 10'h000, 1, 4, "R8 second pop");

    gie_clr = 1; tick();
    expect_st(S_CTRL, 10'h000, 0, 0, "R5 disable");
    ack = 1; tick();
    expect_st(S_PEND, 10'h090, 0, 0, "R6 stray ack pend");
    expect_st(S_ISVC, 10'h000, 0, 0, "R6 stray ack isvc");

    wr(S_MASK, 10'h3FF); irq_src[0] = 1; gie_set = 1; tick();
    expect_st(S_PEND, 10'h091, 1, 0, "R4 sync ignores mask");
    ack = 1; tick();
    expect_st(S_ISVC, 10'h001, 0, 0, "R6 sync taken");
    rti = 1; tick();
    expect_st(S_ISVC, 10'h000, 0, 0, "R8 sync retired");

    irq_src[8] = 1; tick();
    expect_st(S_PEND, 10'h090, 0, 0, "R9 reserved line ignored");
    wr(S_PEND, 10'h100); irq_src[9] = 1; tick();
    expect_st(S_PEND, 10'h200, 0, 0, "R10 write then OR, R9 reserved write dropped");

    gie_set = 1; gie_clr = 1; tick();
    expect_st(S_CTRL, 10'h000, 0, 0, "R5 clear wins");

    wr(S_ISVC, 10'h008); tick();
    expect_st(S_ISVC, 10'h008, 0, 0, "R10 isvc write");
    wr(S_MASK, 10'h000); tick();
    gie_set = 1; tick();
    expect_st(S_PEND, 10'h200, 0, 0, "R7 user below active timer0");
    irq_src[1] = 1; tick();
    expect_st(S_PEND, 10'h202, 1, 1, "R7 swex preempts timer0");
    ack = 1; rti = 1; tick();
    expect_st(S_ISVC, 10'h002, 0, 0, "R8 rti with ack same cycle");
    expect_st(S_PEND, 10'h200, 0, 0, "R6 pend after combined");

    finish_run();
  end
endmodule